// File: doc/BRIEF.md
# Reservation Station Pool with Tag-Matched Operand Capture

This block holds a small set of waiting operations in front of a single arithmetic unit. An upstream issue stage writes an operation into a free slot. For each of its two sources, the issue stage supplies either a ready value or the nonzero tag of the producer that will deliver it later. The pool's answer to each issue is the tag of the slot it was given, which the upstream renaming logic can record as the producer of the destination.

A shared result bus carries a data word and the tag of its producer. Every waiting slot compares its pending source tags against that bus. On a match, the slot takes the word and marks the source as present. One broadcast can therefore wake several slots in the same cycle. A slot whose two sources are both present becomes a candidate for dispatch, and the oldest candidate goes to the unit.

The unit is modelled as a non-pipelined add/subtract stage with a fixed latency. When it finishes, it drives its result, tagged with the slot's own tag, on the result output, and that slot becomes free again. A flush input drops all pending and running work.

Top module: `rs_pool`

## Requirements
- R1: After a synchronous reset, every slot is free: iss_ready is 1, iss_tag is BASE_TAG (default 1) and res_valid is 0.
- R2: iss_ready is 1 exactly when at least one slot is free. An accepted issue goes to the lowest-numbered free slot, and iss_tag equals BASE_TAG plus that slot index (slots 0..3 carry tags 1..4 by default).
- R3: An issue request while iss_ready is 0 is dropped: no slot changes and no later result stems from it.
- R4: A source tag of 0 marks the value as present. A slot may be dispatched only once both of its source tags are 0.
- R5: When bc_valid is 1, every waiting slot whose pending nonzero source tag equals bc_tag takes bc_data into that source and clears the tag, all in the same cycle. bc_tag is never 0 while bc_valid is 1.
- R6: If an issued source tag equals bc_tag while bc_valid is 1 in the issue cycle, the new slot stores bc_data for that source and treats it as present.
- R7: Among several dispatchable slots, the one allocated earliest is sent to the unit first, regardless of slot index.
- R8: A slot becomes dispatchable in the cycle after its last source arrives (or after issue). It is dispatched at the end of that cycle if the unit is free. res_valid is then 1 for one cycle, LAT cycles later (default 3). In that cycle res_data is the first source plus the second (iss_op 0) or the first minus the second (iss_op 1), modulo 2^64, and res_tag is the slot's tag.
- R9: A slot is freed at the end of the cycle in which its result is shown, so iss_ready can rise and its tag can be reused in the next cycle.
- R10: Flush frees every slot and cancels any running operation. It overrides an issue or broadcast in the same cycle, and res_valid is 0 in the following cycle.
- R11: The unit holds one operation at a time. A new dispatch can happen no earlier than the cycle in which the previous result is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop all pending and running work |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 1 | 0 add, 1 subtract |
| iss_qj | input | 4 | Producer tag of first source, 0 if value given |
| iss_vj | input | 64 | Value of first source |
| iss_qk | input | 4 | Producer tag of second source, 0 if value given |
| iss_vk | input | 64 | Value of second source |
| iss_ready | output | 1 | A slot is free |
| iss_tag | output | 4 | Tag of the slot an issue in this cycle receives |
| bc_valid | input | 1 | Result bus carries a value |
| bc_tag | input | 4 | Producer tag on the result bus |
| bc_data | input | 64 | Value on the result bus |
| res_valid | output | 1 | Unit result valid |
| res_tag | output | 4 | Tag of the slot that produced the result |
| res_data | output | 64 | Unit result |

## Verification
The assertions assume that a valid broadcast never carries tag 0, since 0 is reserved for present operands. They also assume that allocation requests reach at most one slot per cycle. The stimulus only broadcasts tags drawn from a nonzero set, and it issues through the single port, so neither assumption is violated. The properties accept any issue attempt while the pool is full, because the stall is enforced inside the block. The bench deliberately drives such attempts, together with flushes that coincide with issues and broadcasts.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int DEF_DATA_W = 64;
    localparam int DEF_TAG_W  = 4;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_EXEC = 2'd2
    } slot_state_e;

    typedef enum logic {
        FU_ADD = 1'b0,
        FU_SUB = 1'b1
    } fu_op_e;

endpackage

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int TAG_W  = DEF_TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              alloc,
    input  fu_op_e            alloc_op,
    input  logic [TAG_W-1:0]  alloc_qj,
    input  logic [DATA_W-1:0] alloc_vj,
    input  logic [TAG_W-1:0]  alloc_qk,
    input  logic [DATA_W-1:0] alloc_vk,
    input  logic              grant,
    input  logic              retire,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              busy,
    output logic              ready,
    output fu_op_e            op,
    output logic [DATA_W-1:0] vj,
    output logic [DATA_W-1:0] vk
);

    typedef struct packed {
        logic [TAG_W-1:0]  q;
        logic [DATA_W-1:0] v;
    } opnd_t;

    slot_state_e st;
    opnd_t       sj, sk;
    opnd_t       base_j, base_k;
    opnd_t       nj, nk;

    function automatic opnd_t snoop(opnd_t o, logic hit_v,
                                    logic [TAG_W-1:0] t, logic [DATA_W-1:0] d);
        opnd_t r;
        r = o;
        if (hit_v && (o.q != '0) && (o.q == t)) begin
            r.q = '0;
            r.v = d;
        end
        return r;
    endfunction

    // Operand source: fresh issue data or held state, then bus capture.
    always_comb begin
        if (alloc) begin
            base_j.q = alloc_qj;
            base_j.v = alloc_vj;
            base_k.q = alloc_qk;
            base_k.v = alloc_vk;
        end else begin
            base_j = sj;
            base_k = sk;
        end
        nj = snoop(base_j, bc_valid, bc_tag, bc_data);
        nk = snoop(base_k, bc_valid, bc_tag, bc_data);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st <= SLOT_FREE;
            sj <= '0;
            sk <= '0;
            op <= FU_ADD;
        end else if (alloc) begin
            st <= SLOT_WAIT;
            op <= alloc_op;
            sj <= nj;
            sk <= nk;
        end else begin
            case (st)
                SLOT_WAIT: begin
                    sj <= nj;
                    sk <= nk;
                    if (grant) st <= SLOT_EXEC;
                end
                SLOT_EXEC: begin
                    if (retire) st <= SLOT_FREE;
                end
                default: ;
            endcase
        end
    end

    assign busy  = (st != SLOT_FREE);
    assign ready = (st == SLOT_WAIT) && (sj.q == '0) && (sk.q == '0);
    assign vj    = sj.v;
    assign vk    = sk.v;

    // R2: the pool only allocates slots that are currently free
    p_alloc_free_r2: assert property (@(posedge clk) disable iff (rst)
        alloc |-> (st == SLOT_FREE));

    // R5: a matching broadcast is taken into a waiting first source
    p_capture_j_r5: assert property (@(posedge clk) disable iff (rst)
        (st == SLOT_WAIT && !alloc && !flush && sj.q != '0 && bc_valid && bc_tag == sj.q)
        |=> (sj.q == '0 && sj.v == $past(bc_data)));

    // R5: same for the second source
    p_capture_k_r5: assert property (@(posedge clk) disable iff (rst)
        (st == SLOT_WAIT && !alloc && !flush && sk.q != '0 && bc_valid && bc_tag == sk.q)
        |=> (sk.q == '0 && sk.v == $past(bc_data)));

    // R4: dispatch only when both sources are present
    p_grant_ready_r4: assert property (@(posedge clk) disable iff (rst)
        grant |-> (sj.q == '0 && sk.q == '0));

endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] alloc_vec,
    input  logic [N-1:0] ready_vec,
    input  logic         fu_free,
    output logic [N-1:0] grant_vec
);

    // older[j][i] set means slot j was allocated before slot i.
    logic [N-1:0] older [N];
    logic [N-1:0] blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < N; j++) older[j] <= '0;
        end else begin
            for (int j = 0; j < N; j++) begin
                for (int k = 0; k < N; k++) begin
                    if (alloc_vec[k])      older[j][k] <= (j != k);
                    else if (alloc_vec[j]) older[j][k] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (ready_vec[j] && older[j][i]) blocked[i] = 1'b1;
            end
            grant_vec[i] = fu_free && ready_vec[i] && !blocked[i];
        end
    end

    // R11: at most one slot is handed to the unit per cycle
    p_one_grant_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec));

    // R2: allocation reaches at most one slot per cycle
    p_alloc_single_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(alloc_vec));

endmodule

// File: rtl/rs_fu.sv
module rs_fu
    import rs_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int IDX_W  = 2,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  fu_op_e            start_op,
    input  logic [DATA_W-1:0] start_a,
    input  logic [DATA_W-1:0] start_b,
    output logic              done,
    output logic [IDX_W-1:0]  done_idx,
    output logic [DATA_W-1:0] result,
    output logic              free
);

    localparam int CNT_W = (LAT < 2) ? 1 : $clog2(LAT);

    logic              busy;
    logic [CNT_W-1:0]  cnt;
    fu_op_e            op_r;
    logic [DATA_W-1:0] a_r, b_r;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            busy     <= 1'b0;
            cnt      <= '0;
            op_r     <= FU_ADD;
            a_r      <= '0;
            b_r      <= '0;
            done_idx <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            cnt      <= CNT_W'(LAT - 1);
            op_r     <= start_op;
            a_r      <= start_a;
            b_r      <= start_b;
            done_idx <= start_idx;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done   = busy && (cnt == '0);
    assign free   = !busy || done;
    assign result = (op_r == FU_SUB) ? (a_r - b_r) : (a_r + b_r);

    // R11: the selector never starts work on an occupied unit
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
        start |-> (!busy || done));

    generate
        if (LAT > 1) begin : g_multi
            // R8: a result is shown for a single cycle
            p_single_done_r8: assert property (@(posedge clk) disable iff (rst)
                done |=> !done);
        end
    endgenerate

endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pkg::*;
#(
    parameter int N        = 4,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int TAG_W    = DEF_TAG_W,
    parameter int BASE_TAG = 1,
    parameter int LAT      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              iss_valid,
    input  logic              iss_op,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qk,
    input  logic [DATA_W-1:0] iss_vk,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag,
    output logic [DATA_W-1:0] res_data
);

    localparam int IDX_W = (N < 2) ? 1 : $clog2(N);

    logic [N-1:0]      busy_vec, ready_vec, alloc_vec, grant_vec, retire_vec;
    fu_op_e            ent_op [N];
    logic [DATA_W-1:0] ent_vj [N];
    logic [DATA_W-1:0] ent_vk [N];

    logic              any_free;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  g_idx;
    fu_op_e            g_op;
    logic [DATA_W-1:0] g_vj, g_vk;
    logic              fu_free, fu_done;
    logic [IDX_W-1:0]  fu_idx;

    // Lowest-numbered free slot receives the next issue.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign iss_ready = any_free;
    assign iss_tag   = TAG_W'(BASE_TAG) + TAG_W'(free_idx);

    generate
        for (genvar i = 0; i < N; i++) begin : g_slot
            assign alloc_vec[i]  = iss_valid && any_free && !flush && (free_idx == IDX_W'(i));
            assign retire_vec[i] = fu_done && (fu_idx == IDX_W'(i));

            rs_entry #(
                .DATA_W (DATA_W),
                .TAG_W  (TAG_W)
            ) u_entry (
                .clk      (clk),
                .rst      (rst),
                .flush    (flush),
                .alloc    (alloc_vec[i]),
                .alloc_op (fu_op_e'(iss_op)),
                .alloc_qj (iss_qj),
                .alloc_vj (iss_vj),
                .alloc_qk (iss_qk),
                .alloc_vk (iss_vk),
                .grant    (grant_vec[i]),
                .retire   (retire_vec[i]),
                .bc_valid (bc_valid),
                .bc_tag   (bc_tag),
                .bc_data  (bc_data),
                .busy     (busy_vec[i]),
                .ready    (ready_vec[i]),
                .op       (ent_op[i]),
                .vj       (ent_vj[i]),
                .vk       (ent_vk[i])
            );
        end
    endgenerate

    rs_age_pick #(
        .N (N)
    ) u_pick (
        .clk       (clk),
        .rst       (rst),
        .alloc_vec (alloc_vec),
        .ready_vec (ready_vec),
        .fu_free   (fu_free),
        .grant_vec (grant_vec)
    );

    always_comb begin
        g_idx = '0;
        g_op  = FU_ADD;
        g_vj  = '0;
        g_vk  = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_vec[i]) begin
                g_idx = IDX_W'(i);
                g_op  = ent_op[i];
                g_vj  = ent_vj[i];
                g_vk  = ent_vk[i];
            end
        end
    end

    rs_fu #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .LAT    (LAT)
    ) u_fu (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .start     (|grant_vec),
        .start_idx (g_idx),
        .start_op  (g_op),
        .start_a   (g_vj),
        .start_b   (g_vk),
        .done      (fu_done),
        .done_idx  (fu_idx),
        .result    (res_data),
        .free      (fu_free)
    );

    assign res_valid = fu_done;
    assign res_tag   = TAG_W'(BASE_TAG) + TAG_W'(fu_idx);

    // R10: flush leaves every slot free and no result pending
    p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (iss_ready && !res_valid));

    // R3: a full pool with no completing result stays full
    p_full_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (!iss_ready && !res_valid && !flush) |=> !iss_ready);

    // R5: a valid broadcast never carries the reserved tag 0
    p_bc_tag_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        bc_valid |-> (bc_tag != '0));

endmodule

// File: tb/rs_pool_test.sv
module rs_pool_test;

    localparam int N    = 4;
    localparam int LAT  = 3;
    localparam int BASE = 1;

    logic        clk = 1'b0;
    logic        rst, flush;
    logic        iss_valid, iss_op;
    logic [3:0]  iss_qj, iss_qk;
    logic [63:0] iss_vj, iss_vk;
    logic        iss_ready;
    logic [3:0]  iss_tag;
    logic        bc_valid;
    logic [3:0]  bc_tag;
    logic [63:0] bc_data;
    logic        res_valid;
    logic [3:0]  res_tag;
    logic [63:0] res_data;

    always #4 clk = ~clk;

    rs_pool uut (
        .clk(clk), .rst(rst), .flush(flush),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_qj(iss_qj), .iss_vj(iss_vj), .iss_qk(iss_qk), .iss_vk(iss_vk),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    // Behavioural reference: per-slot records plus an issue order counter.
    int          m_st  [N];
    logic [3:0]  m_qj  [N];
    logic [3:0]  m_qk  [N];
    logic [63:0] m_vj  [N];
    logic [63:0] m_vk  [N];
    int          m_op  [N];
    int          m_seq [N];
    int          seqc = 0;
    bit          f_busy = 0;
    int          f_cnt = 0, f_idx = 0, f_op = 0;
    logic [63:0] f_a = 0, f_b = 0;

    task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        bit          e_ready = 0;
        int          lf = -1;
        bit          e_rv;
        logic [63:0] e_rd;
        for (int i = N - 1; i >= 0; i--) if (m_st[i] == 0) lf = i;
        e_ready = (lf >= 0);
        chk(iss_ready === e_ready, "iss_ready", 64'(iss_ready), 64'(e_ready));
        if (e_ready)
            chk(iss_tag === 4'(BASE + lf), "iss_tag", 64'(iss_tag), 64'(BASE + lf));
        e_rv = f_busy && (f_cnt == 0);
        chk(res_valid === e_rv, "res_valid", 64'(res_valid), 64'(e_rv));
        if (e_rv) begin
            e_rd = (f_op != 0) ? (f_a - f_b) : (f_a + f_b);
            chk(res_tag === 4'(BASE + f_idx), "res_tag", 64'(res_tag), 64'(BASE + f_idx));
            chk(res_data === e_rd, "res_data", res_data, e_rd);
        end
    endtask

    task automatic model_next();
        bit rv, ffree;
        int lf = -1, pick = -1, best = 0;
        if (rst || flush) begin
            for (int i = 0; i < N; i++) m_st[i] = 0;
            f_busy = 0;
            return;
        end
        rv = f_busy && (f_cnt == 0);
        for (int i = N - 1; i >= 0; i--) if (m_st[i] == 0) lf = i;
        for (int i = 0; i < N; i++)
            if (m_st[i] == 1 && m_qj[i] == 0 && m_qk[i] == 0)
                if (pick < 0 || m_seq[i] < best) begin pick = i; best = m_seq[i]; end
        ffree = !f_busy || rv;
        if (rv) m_st[f_idx] = 0;
        if (pick >= 0 && ffree) begin
            m_st[pick] = 2; f_busy = 1; f_cnt = LAT - 1; f_idx = pick;
            f_op = m_op[pick]; f_a = m_vj[pick]; f_b = m_vk[pick];
        end else if (rv) f_busy = 0;
        else if (f_busy) f_cnt--;
        if (bc_valid)
            for (int i = 0; i < N; i++) if (m_st[i] == 1) begin
                if (m_qj[i] != 0 && m_qj[i] == bc_tag) begin m_qj[i] = 0; m_vj[i] = bc_data; end
                if (m_qk[i] != 0 && m_qk[i] == bc_tag) begin m_qk[i] = 0; m_vk[i] = bc_data; end
            end
        if (iss_valid && lf >= 0) begin
            m_st[lf] = 1; m_op[lf] = int'(iss_op);
            m_qj[lf] = iss_qj; m_vj[lf] = iss_vj; m_qk[lf] = iss_qk; m_vk[lf] = iss_vk;
            if (bc_valid && iss_qj != 0 && iss_qj == bc_tag) begin m_qj[lf] = 0; m_vj[lf] = bc_data; end
            if (bc_valid && iss_qk != 0 && iss_qk == bc_tag) begin m_qk[lf] = 0; m_vk[lf] = bc_data; end
            m_seq[lf] = seqc++;
        end
    endtask

    // Called at a falling edge after inputs are driven.
    task automatic tick();
        #2;
        if (!rst) compare();
        model_next();
        @(negedge clk);
    endtask

    task automatic clr();
        flush = 0; iss_valid = 0; iss_op = 0; iss_qj = 0; iss_qk = 0;
        iss_vj = 0; iss_vk = 0; bc_valid = 0; bc_tag = 0; bc_data = 0;
    endtask

    task automatic issue(bit op, logic [3:0] qj, logic [63:0] vj, logic [3:0] qk, logic [63:0] vk);
        iss_valid = 1; iss_op = op; iss_qj = qj; iss_vj = vj; iss_qk = qk; iss_vk = vk;
    endtask

    task automatic bcast(logic [3:0] t, logic [63:0] d);
        bc_valid = 1; bc_tag = t; bc_data = d;
    endtask

    task automatic idle(int n);
        clr();
        for (int i = 0; i < n; i++) tick();
    endtask

    function automatic logic [3:0] rtag();
        int r = $urandom_range(0, 4);
        return (r < 2) ? 4'd0 : 4'(r + 4);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        clr();
        rst = 1;
        @(negedge clk);
        tick(); tick();
        rst = 0;
        cur_req = "R1"; idle(2);

        cur_req = "R8";
        issue(0, 0, 64'd5, 0, 64'd7); tick();
        idle(6);
        issue(1, 0, 64'd3, 0, 64'd10); tick();
        idle(6);

        cur_req = "R5";
        issue(0, 4'd9, 0, 0, 64'd100); tick();
        issue(1, 0, 64'd50, 4'd9, 0); tick();
        idle(1);
        bcast(4'd9, 64'd20); tick();
        idle(10);

        cur_req = "R6";
        issue(0, 4'd10, 0, 0, 64'd1); bcast(4'd10, 64'd41); tick();
        idle(6);

        cur_req = "R7";
        issue(0, 0, 64'd1, 0, 64'd1); tick();
        issue(0, 4'd12, 0, 0, 64'd2); tick();
        idle(5);
        issue(1, 4'd12, 0, 0, 64'd3); tick();
        clr(); bcast(4'd12, 64'd9); tick();
        idle(10);

        cur_req = "R2";
        for (int i = 0; i < N; i++) begin issue(0, 4'd14, 0, 0, 64'(i)); tick(); end
        cur_req = "R3";
        issue(0, 0, 64'hdead, 0, 64'hbeef); tick(); tick();
        clr(); tick();
        cur_req = "R9";
        bcast(4'd14, 64'd1000); tick();
        idle(20);

        cur_req = "R11";
        for (int i = 0; i < 3; i++) begin issue(0, 0, 64'(i), 0, 64'd2); tick(); end
        idle(15);

        cur_req = "R10";
        issue(0, 4'd6, 0, 0, 64'd1); tick();
        issue(0, 0, 64'd4, 0, 64'd4); tick();
        issue(1, 4'd7, 0, 0, 64'd5); tick();
        clr(); flush = 1; issue(0, 0, 64'd8, 0, 64'd8); bcast(4'd6, 64'd3); tick();
        idle(6);

        cur_req = "R4";
        for (int c = 0; c < 3000; c++) begin
            clr();
            if ($urandom_range(0, 2) != 0)
                issue(1'($urandom_range(0, 1)), rtag(), {$urandom, $urandom},
                      rtag(), {$urandom, $urandom});
            if ($urandom_range(0, 2) == 0)
                bcast(4'($urandom_range(6, 8)), {$urandom, $urandom});
            if ($urandom_range(0, 199) == 0) flush = 1;
            tick();
        end
        idle(60);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule